// File: doc/BRIEF.md
# Bit-Serial Configuration Register Loader

This block holds four 12-bit configuration words used by a downstream digital lock detector: an integration constant, a decay constant, a lock threshold and an unlock threshold. The host never writes a whole word. Instead it writes one 8-bit control byte at a time. Each byte carries a strobe flag, one data bit, a 2-bit register select and a 4-bit bit index.

When the strobe flag moves from 0 to 1 between successive accepted bytes, the data bit is deposited into the selected word. The position is counted from the most significant end. A full word therefore takes twelve pairs of writes, most significant bit first. Each pair is one byte with the strobe clear, then the same byte with the strobe set.

All four words are driven out as registered outputs. The integration word serves both as a configuration output and as an observation port.

Top module: `cfg_serial_loader`

## Requirements
- R1: A synchronous active-high reset clears all four configuration words to zero.
- R2: Control byte layout, with vector bit 7 as the most significant bit: bit 7 is the strobe, bit 6 is the data bit, bits 5:4 are the register select (5 is the MSB), and bits 3:0 are the bit index (3 is the MSB). A byte is accepted only in a cycle where `wr_en` is high.
- R3: An accepted byte whose strobe is 1, when the previously accepted strobe was 0, commits its data bit. For bit index k, the bit lands at word position 11 − k. The change appears on the outputs after the second rising clock edge, counting the edge that accepts the byte.
- R4: Register select 0 addresses `integ_q`, 1 addresses `decay_q`, 2 addresses `lock_thr_q` and 3 addresses `unlock_thr_q`.
- R5: Further accepted bytes with the strobe still at 1 commit nothing, whatever their other fields hold.
- R6: A commit whose bit index is 12, 13, 14 or 15 changes no word.
- R7: Twelve strobe-low/strobe-high byte pairs with indices 0 to 11, carrying a value MSB first, load that value. Loading 00Ah into the integration word makes `integ_q` read 00Ah.
- R8: A commit changes at most the one addressed bit. Every other bit and every other word keeps its value, and without a commit no word changes.
- R9: A byte presented while `wr_en` is low is ignored, even if its strobe bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host write enable for the control byte |
| wr_byte | input | 8 | Control byte (strobe, data, select, index) |
| integ_q | output | 12 | Integration word, also the observation port |
| decay_q | output | 12 | Decay word |
| lock_thr_q | output | 12 | Lock threshold word |
| unlock_thr_q | output | 12 | Unlock threshold word |

## Verification
A byte that raises the strobe is accepted at one clock edge, and the addressed bit shows on the outputs only after the next edge. Any other accepted byte leaves the outputs unchanged at both edges.

The bench drives stimulus on falling edges. Its reference model sees each accepted byte at the rising edge, decides from its own record of the last accepted strobe whether a commit is due, and schedules the bit for the following rising edge. Outputs are compared against the model at every falling edge.

The latency test additionally checks that the output is still old after the accepting edge and new after the next one.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  localparam int CFG_REG_W    = 12;
  localparam int CFG_NUM_REGS = 4;
  localparam int CFG_SEL_W    = 2;
  localparam int CFG_IDX_W    = 4;

  typedef enum logic [CFG_SEL_W-1:0] {
    SEL_INTEG  = 2'd0,
    SEL_DECAY  = 2'd1,
    SEL_LOCK   = 2'd2,
    SEL_UNLOCK = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/cfgld_ctl_decode.sv
module cfgld_ctl_decode #(
  parameter int SEL_W = 2,
  parameter int IDX_W = 4,
  localparam int BYTE_W = 2 + SEL_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic              commit,
  output logic              strobe,
  output logic              data,
  output logic [SEL_W-1:0]  sel,
  output logic [IDX_W-1:0]  idx
);
  localparam int STB_POS = BYTE_W - 1;
  localparam int DAT_POS = BYTE_W - 2;
  localparam int SEL_LSB = IDX_W;

  logic [BYTE_W-1:0] ctl_q;
  logic              strobe_d;

  // control byte holding register and delayed strobe for edge detect
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q    <= '0;
      strobe_d <= 1'b0;
    end else begin
      if (wr_en) ctl_q <= wr_byte;
      strobe_d <= ctl_q[STB_POS];
    end
  end

  assign strobe = ctl_q[STB_POS];
  assign data   = ctl_q[DAT_POS];
  assign sel    = ctl_q[SEL_LSB +: SEL_W];
  assign idx    = ctl_q[IDX_W-1:0];
  assign commit = strobe & ~strobe_d;
endmodule

// File: rtl/cfgld_reg_slot.sv
module cfgld_reg_slot #(
  parameter int REG_W = 12,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             data,
  input  logic [IDX_W-1:0] idx,
  output logic [REG_W-1:0] value_q
);
  // index k addresses bit REG_W-1-k; indices past the word match no bit
  always_ff @(posedge clk) begin
    if (rst) begin
      value_q <= '0;
    end else if (we) begin
      for (int b = 0; b < REG_W; b++) begin
        if (idx == IDX_W'(REG_W - 1 - b)) value_q[b] <= data;
      end
    end
  end
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfgld_pkg::*;
#(
  parameter int REG_W    = CFG_REG_W,
  parameter int NUM_REGS = CFG_NUM_REGS,
  parameter int SEL_W    = CFG_SEL_W,
  parameter int IDX_W    = CFG_IDX_W,
  localparam int BYTE_W  = 2 + SEL_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [REG_W-1:0]  integ_q,
  output logic [REG_W-1:0]  decay_q,
  output logic [REG_W-1:0]  lock_thr_q,
  output logic [REG_W-1:0]  unlock_thr_q
);
  logic                               commit_w;
  logic                               strobe_w;
  logic                               data_w;
  logic [SEL_W-1:0]                   sel_w;
  logic [IDX_W-1:0]                   idx_w;
  logic [NUM_REGS-1:0][REG_W-1:0]     bank_w;

  cfgld_ctl_decode #(.SEL_W(SEL_W), .IDX_W(IDX_W)) u_dec (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_byte(wr_byte),
    .commit (commit_w),
    .strobe (strobe_w),
    .data   (data_w),
    .sel    (sel_w),
    .idx    (idx_w)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    cfgld_reg_slot #(.REG_W(REG_W), .IDX_W(IDX_W)) u_slot (
      .clk    (clk),
      .rst    (rst),
      .we     (commit_w && (sel_w == SEL_W'(g))),
      .data   (data_w),
      .idx    (idx_w),
      .value_q(bank_w[g])
    );
  end

  assign integ_q      = bank_w[SEL_INTEG];
  assign decay_q      = bank_w[SEL_DECAY];
  assign lock_thr_q   = bank_w[SEL_LOCK];
  assign unlock_thr_q = bank_w[SEL_UNLOCK];
endmodule

// File: rtl/cfgld_checker.sv
module cfgld_checker #(
  parameter int REG_W    = 12,
  parameter int NUM_REGS = 4,
  parameter int SEL_W    = 2,
  parameter int IDX_W    = 4
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           commit,
  input logic                           strobe,
  input logic                           data,
  input logic [SEL_W-1:0]               sel,
  input logic [IDX_W-1:0]               idx,
  input logic [NUM_REGS-1:0][REG_W-1:0] regs
);
  logic             rst_q     = 1'b0;
  logic             pend_q    = 1'b0;
  logic [SEL_W-1:0] snap_sel  = '0;
  logic [IDX_W-1:0] snap_pos  = '0;
  logic             snap_data = 1'b0;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q) begin
      p_reset_zero_r1 : assert (regs == '0);
    end
    if (pend_q && !rst_q) begin
      p_bit_landed_r3 : assert (regs[snap_sel][snap_pos] == snap_data);
    end
    pend_q    <= !rst && commit && (int'(idx) < REG_W);
    snap_sel  <= sel;
    snap_pos  <= IDX_W'(REG_W - 1) - idx;
    snap_data <= data;
  end

  p_commit_on_rise_r3 : assert property (@(posedge clk) disable iff (rst)
    commit |-> (strobe && !$past(strobe)));

  p_no_double_commit_r5 : assert property (@(posedge clk) disable iff (rst)
    commit |=> !commit);

  p_high_index_ignored_r6 : assert property (@(posedge clk) disable iff (rst)
    (commit && int'(idx) >= REG_W) |=> $stable(regs));

  p_quiet_without_commit_r8 : assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(regs));

  p_single_bit_r8 : assert property (@(posedge clk) disable iff (rst)
    commit |=> ($countones(regs ^ $past(regs)) <= 1));
endmodule

bind cfg_serial_loader cfgld_checker #(
  .REG_W(REG_W), .NUM_REGS(NUM_REGS), .SEL_W(SEL_W), .IDX_W(IDX_W)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .commit(commit_w),
  .strobe(strobe_w),
  .data  (data_w),
  .sel   (sel_w),
  .idx   (idx_w),
  .regs  (bank_w)
);

// File: tb/cfg_serial_loader_tb.sv
module cfg_serial_loader_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_byte = '0;
  logic [11:0] integ_q, decay_q, lock_thr_q, unlock_thr_q;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit cmp_on = 0;
  string cur_req = "R2";

  always #5 clk = ~clk;

  cfg_serial_loader u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_byte(wr_byte),
    .integ_q(integ_q), .decay_q(decay_q),
    .lock_thr_q(lock_thr_q), .unlock_thr_q(unlock_thr_q)
  );

  // reference model: pending commits with their due edge
  typedef struct { int due; int sel; int pos; bit val; } pend_t;
  pend_t pq[$];
  logic [11:0] model [4];
  bit last_stb = 0;
  int cyc = 0;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      for (int i = 0; i < 4; i++) model[i] = '0;
      last_stb = 0;
      pq.delete();
    end else begin
      while (pq.size() > 0 && pq[0].due == cyc) begin
        pend_t p;
        p = pq.pop_front();
        if (p.pos >= 0) model[p.sel][p.pos] = p.val;
      end
      if (wr_en) begin
        if (wr_byte[7] && !last_stb) begin
          pend_t n;
          n.due = cyc + 1;
          n.sel = int'(wr_byte[5:4]);
          n.pos = (int'(wr_byte[3:0]) < 12) ? 11 - int'(wr_byte[3:0]) : -1;
          n.val = wr_byte[6];
          pq.push_back(n);
        end
        last_stb = wr_byte[7];
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      total++;
      if (integ_q !== model[0] || decay_q !== model[1] ||
          lock_thr_q !== model[2] || unlock_thr_q !== model[3]) begin
        bad++;
        $display("FAIL %s cycle %0d: actual %h %h %h %h expected %h %h %h %h", cur_req, cyc,
                 integ_q, decay_q, lock_thr_q, unlock_thr_q,
                 model[0], model[1], model[2], model[3]);
      end
    end
  end

  function automatic logic [7:0] mk(bit stb, bit d, int sel, int idx);
    return {stb, d, 2'(sel), 4'(idx)};
  endfunction

  task automatic check12(string req, logic [11:0] act, logic [11:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1; wr_byte = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(int sel, logic [11:0] v);
    for (int k = 0; k < 12; k++) begin
      wr(mk(0, v[11-k], sel, k));
      wr(mk(1, v[11-k], sel, k));
      repeat (24) @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [15:0] lf;
    logic [11:0] snap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cur_req = "R1";
    check12("R1 integ", integ_q, 12'h000);
    check12("R1 decay", decay_q, 12'h000);
    check12("R1 lock", lock_thr_q, 12'h000);
    check12("R1 unlock", unlock_thr_q, 12'h000);
    cmp_on = 1;

    cur_req = "R7";
    load(0, 12'h00A);
    check12("R7 integ 00A", integ_q, 12'h00A);

    cur_req = "R4";
    load(1, 12'h001);
    load(2, 12'h004);
    load(3, 12'h006);
    check12("R4 decay", decay_q, 12'h001);
    check12("R4 lock", lock_thr_q, 12'h004);
    check12("R4 unlock", unlock_thr_q, 12'h006);
    check12("R8 integ kept", integ_q, 12'h00A);

    // R3 latency: bit index 0 of decay -> position 11
    cur_req = "R3";
    wr(mk(0, 1, 1, 0));
    @(negedge clk);
    wr_en = 1'b1; wr_byte = mk(1, 1, 1, 0);
    @(negedge clk);
    wr_en = 1'b0;
    check12("R3 after accept edge", decay_q, 12'h001);
    @(negedge clk);
    check12("R3 after next edge", decay_q, 12'h801);

    // R5: strobe held at 1, new fields do not commit
    cur_req = "R5";
    wr(mk(1, 1, 1, 5));
    wr(mk(1, 1, 0, 0));
    repeat (3) @(negedge clk);
    check12("R5 decay", decay_q, 12'h801);
    check12("R5 integ", integ_q, 12'h00A);

    // R6: high indices ignored
    cur_req = "R6";
    for (int k = 12; k < 16; k++) begin
      wr(mk(0, 1, 2, k));
      wr(mk(1, 1, 2, k));
    end
    repeat (3) @(negedge clk);
    check12("R6 lock", lock_thr_q, 12'h004);

    // R9: strobe rise presented without wr_en
    cur_req = "R9";
    wr(mk(0, 1, 3, 0));
    @(negedge clk);
    wr_byte = mk(1, 1, 3, 0);
    repeat (4) @(negedge clk);
    check12("R9 unlock", unlock_thr_q, 12'h006);

    // R2/R8: pseudo-random byte stream compared every cycle
    cur_req = "R8";
    lf = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      @(negedge clk);
      wr_en = lf[0] | lf[1];
      wr_byte = lf[15:8];
    end
    @(negedge clk);
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    snap = integ_q;
    check12("R2 integ model", snap, model[0]);

    // R1 again mid-run
    cur_req = "R1";
    cmp_on = 0;
    load(0, 12'hFFF);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check12("R1 re-reset integ", integ_q, 12'h000);
    check12("R1 re-reset decay", decay_q, 12'h000);

    finish_run();
  end
endmodule